// File: doc/BRIEF.md
# Frame-Interface Interrupt and Receive Gate

This block holds the control and status state for a secondary frame-exchange interface. An 8-bit command register sets the interrupt-pin enable, two per-event interrupt masks, a loopback enable and a runt-accept enable. An 8-bit interrupt register reports a transmit-done bit, a receive-done bit and a summary flag. Both registers are reached through a simple register port: one select line, a write strobe and a read strobe. Read data is combinational.

Transmit-done and receive-done event pulses set sticky status bits. A read of the interrupt register clears these bits. A registered, active-high interrupt pin is raised when an unmasked status bit is set and the pin is enabled.

The same command register also drives a receive gate. At each frame-end strobe the gate gives a one-cycle accept pulse or a one-cycle drop pulse. The decision is built from four inputs: the external filter flag, the frame byte count, whether this side is transmitting, and the duplex mode.

Top module: `frm_irq_gate`

## Requirements
- R1: After reset both registers read 0, and `irqPin`, `frameAccept` and `frameDrop` are all 0.
- R2: Command register bit layout: bit 7 is the pin enable, bit 6 the transmit-done mask, bit 5 the receive-done mask, bit 3 the loopback enable and bit 2 the runt-accept enable. Bits 4, 1 and 0 always read 0, so writing 8'hFF reads back 8'hEC.
- R3: Interrupt register bit layout: bit 7 is the summary flag, bit 6 transmit-done and bit 5 receive-done. Bits 4:0 read 0. Each done bit sets on its event pulse and stays set.
- R4: The summary flag is the OR of the done bits whose mask is 0. A masked done bit still sets and still reads back.
- R5: `irqPin` goes high one cycle after the summary flag is 1 while the pin enable is 1. It stays 0 whenever the pin enable is 0.
- R6: A read of the interrupt register (`regSel`=1) returns the current value and then clears both done bits. A write to the interrupt register changes nothing.
- R7: If an event pulse arrives in the same cycle as a read of the interrupt register, the read returns the old value and the event's done bit is left set.
- R8: Each `frameEnd` strobe gives, in the next cycle, exactly one one-cycle pulse on either `frameAccept` or `frameDrop`. No pulse appears without a strobe.
- R9: A frame whose `filterPass` is 0 is always dropped.
- R10: In half duplex, a frame that ends while `txActive` is 1 is dropped when loopback is 0. It is accepted when loopback is 1 (and the other rules allow it).
- R11: In full duplex, `txActive` and loopback have no effect on the decision.
- R12: A frame shorter than `RUNT_MIN` (64) bytes is accepted only when runt-accept is 1. A frame of exactly 64 bytes counts as a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset |
| regSel | input | 1 | 0 selects the command register, 1 selects the interrupt register |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (used for clear-on-read) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the selected register |
| txDoneEv | input | 1 | Transmit-done event pulse |
| rxDoneEv | input | 1 | Receive-done event pulse |
| fullDuplex | input | 1 | 1 when the link is in full duplex |
| txActive | input | 1 | 1 while this side is transmitting |
| frameEnd | input | 1 | Frame-end strobe |
| frameLen | input | LEN_W | Frame byte count, valid with `frameEnd` |
| filterPass | input | 1 | External filter match, valid with `frameEnd` |
| frameAccept | output | 1 | One-cycle accept pulse |
| frameDrop | output | 1 | One-cycle drop pulse |
| irqPin | output | 1 | Registered, active-high interrupt |

## Verification
Two things can land on the same clock edge: the clear caused by a read of the interrupt register, and the set caused by a done event. The bench drives a receive-done pulse in the same cycle as a read strobe. It then checks two results: the read returns the old, empty value, and a second read shows the receive-done bit and the summary flag still set. The bench also raises `frameEnd` in the same cycle as a command write, to show that the gate judges the frame with the command value from before the write.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;
  // command register bit positions
  localparam int CMD_IRQ_EN   = 7;
  localparam int CMD_TX_MASK  = 6;
  localparam int CMD_RX_MASK  = 5;
  localparam int CMD_LOOP     = 3;
  localparam int CMD_RUNT_OK  = 2;
  localparam logic [7:0] CMD_WR_MASK = 8'hEC;

  // interrupt register bit positions
  localparam int INT_SUMMARY  = 7;
  localparam int INT_TX_DONE  = 6;
  localparam int INT_RX_DONE  = 5;

  typedef struct packed {
    logic cmdWr;
    logic intRd;
    logic frmEval;
    logic rdInt;
  } ctrl_stb_t;
endpackage

// File: rtl/frm_irq_ctrl.sv
module frm_irq_ctrl
  import frm_irq_pkg::*;
(
  input  logic      regSel,
  input  logic      regWr,
  input  logic      regRd,
  input  logic      frameEnd,
  output ctrl_stb_t stb
);
  always_comb begin
    stb.cmdWr   = regWr & ~regSel;
    stb.intRd   = regRd & regSel;
    stb.frmEval = frameEnd;
    stb.rdInt   = regSel;
  end
endmodule

// File: rtl/frm_irq_dp.sv
module frm_irq_dp
  import frm_irq_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int RUNT_MIN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_stb_t        stb,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             txDoneEv,
  input  logic             rxDoneEv,
  input  logic             fullDuplex,
  input  logic             txActive,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             filterPass,
  output logic             frameAccept,
  output logic             frameDrop,
  output logic             irqPin
);
  localparam logic [LEN_W-1:0] RUNT_LIM = LEN_W'(RUNT_MIN);

  logic [7:0] cmdQ;
  logic       txDoneQ, rxDoneQ;
  logic       summary;
  logic [7:0] intVal;
  logic       isRunt, echoBlock, lenOk, acceptNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdQ <= '0;
    else if (stb.cmdWr) cmdQ <= regWdata & CMD_WR_MASK;
  end

  // the event wins over the clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDoneQ <= 1'b0;
      rxDoneQ <= 1'b0;
    end else begin
      txDoneQ <= txDoneEv | (txDoneQ & ~stb.intRd);
      rxDoneQ <= rxDoneEv | (rxDoneQ & ~stb.intRd);
    end
  end

  always_comb begin
    summary = (txDoneQ & ~cmdQ[CMD_TX_MASK]) | (rxDoneQ & ~cmdQ[CMD_RX_MASK]);
    intVal  = '0;
    intVal[INT_SUMMARY] = summary;
    intVal[INT_TX_DONE] = txDoneQ;
    intVal[INT_RX_DONE] = rxDoneQ;
    regRdata = stb.rdInt ? intVal : cmdQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPin <= 1'b0;
    else       irqPin <= summary & cmdQ[CMD_IRQ_EN];
  end

  always_comb begin
    isRunt    = frameLen < RUNT_LIM;
    lenOk     = ~isRunt | cmdQ[CMD_RUNT_OK];
    echoBlock = ~fullDuplex & txActive & ~cmdQ[CMD_LOOP];
    acceptNow = filterPass & lenOk & ~echoBlock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameAccept <= 1'b0;
      frameDrop   <= 1'b0;
    end else begin
      frameAccept <= stb.frmEval & acceptNow;
      frameDrop   <= stb.frmEval & ~acceptNow;
    end
  end
endmodule

// File: rtl/frm_irq_gate.sv
module frm_irq_gate
  import frm_irq_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int RUNT_MIN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             txDoneEv,
  input  logic             rxDoneEv,
  input  logic             fullDuplex,
  input  logic             txActive,
  input  logic             frameEnd,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             filterPass,
  output logic             frameAccept,
  output logic             frameDrop,
  output logic             irqPin
);
  ctrl_stb_t stb;

  frm_irq_ctrl uCtrl (
    .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .frameEnd(frameEnd), .stb(stb)
  );

  frm_irq_dp #(.LEN_W(LEN_W), .RUNT_MIN(RUNT_MIN)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata),
    .regRdata(regRdata), .txDoneEv(txDoneEv), .rxDoneEv(rxDoneEv),
    .fullDuplex(fullDuplex), .txActive(txActive), .frameLen(frameLen),
    .filterPass(filterPass), .frameAccept(frameAccept),
    .frameDrop(frameDrop), .irqPin(irqPin)
  );
endmodule

// File: rtl/frm_irq_chk.sv
module frm_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regSel,
  input logic       regRd,
  input logic [7:0] regRdata,
  input logic       txDoneEv,
  input logic       rxDoneEv,
  input logic       frameEnd,
  input logic       filterPass,
  input logic       frameAccept,
  input logic       frameDrop
);
  // R8
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frameAccept && frameDrop));
  // R8
  eval_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (frameAccept || frameDrop));
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> (!frameAccept && !frameDrop));
  // R9
  filter_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameAccept |-> $past(filterPass));
  // R3
  tx_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDoneEv |=> (!regSel || regRdata[6]));
  // R7
  rx_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneEv |=> (!regSel || regRdata[5]));
  // R6
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel && !txDoneEv && !rxDoneEv) |=> (!regSel || regRdata[6:5] == 2'b00));
  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regSel ? (regRdata[4:0] == 5'd0) : ({regRdata[4], regRdata[1:0]} == 3'd0));
endmodule

bind frm_irq_gate frm_irq_chk uChk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regRd(regRd),
  .regRdata(regRdata), .txDoneEv(txDoneEv), .rxDoneEv(rxDoneEv),
  .frameEnd(frameEnd), .filterPass(filterPass),
  .frameAccept(frameAccept), .frameDrop(frameDrop)
);

// File: tb/tb_frm_irq_gate.sv
module tb_frm_irq_gate;
  logic        clk = 0;
  logic        rstN = 0;
  logic        regSel = 0, regWr = 0, regRd = 0;
  logic [7:0]  regWdata = 0;
  logic [7:0]  regRdata;
  logic        txDoneEv = 0, rxDoneEv = 0, fullDuplex = 0, txActive = 0;
  logic        frameEnd = 0, filterPass = 0;
  logic [15:0] frameLen = 0;
  logic        frameAccept, frameDrop, irqPin;
  int          nRun = 0, nFail = 0;
  logic [7:0]  rv;

  always #5 clk = ~clk;

  frm_irq_gate dut (.*);

  initial begin
    #1000000;
    nRun++; nFail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic sel, logic [7:0] d);
    @(negedge clk); regSel = sel; regWr = 1; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  // returns data seen during the read cycle
  task automatic rdReg(logic sel, output logic [7:0] d);
    @(negedge clk); regSel = sel; regRd = 1; #1 d = regRdata;
    @(negedge clk); regRd = 0;
  endtask

  task automatic peek(logic sel, output logic [7:0] d);
    @(negedge clk); regSel = sel; #1 d = regRdata;
  endtask

  task automatic pulse(logic tx, logic rx);
    @(negedge clk); txDoneEv = tx; rxDoneEv = rx;
    @(negedge clk); txDoneEv = 0; rxDoneEv = 0;
  endtask

  task automatic frame(string req, int len, logic flt, logic txa, logic fd, logic expAcc);
    @(negedge clk); frameEnd = 1; frameLen = 16'(len); filterPass = flt;
    txActive = txa; fullDuplex = fd;
    @(negedge clk); frameEnd = 0;
    chk(req, {6'd0, frameAccept, frameDrop}, {6'd0, expAcc, ~expAcc});
    @(negedge clk);
    chk({req, " one-cycle"}, {6'd0, frameAccept, frameDrop}, 8'd0);
  endtask

  task automatic tReset();
    peek(0, rv); chk("R1 cmd", rv, 8'h00);
    peek(1, rv); chk("R1 int", rv, 8'h00);
    chk("R1 pins", {5'd0, irqPin, frameAccept, frameDrop}, 8'd0);
  endtask

  task automatic tCmdLayout();
    wrReg(0, 8'hFF); peek(0, rv); chk("R2 reserved ignored", rv, 8'hEC);
    wrReg(0, 8'h00); peek(0, rv); chk("R2 clear", rv, 8'h00);
  endtask

  task automatic tStatus();
    pulse(1, 0);
    rdReg(1, rv); chk("R3 tx done + summary", rv, 8'hC0);
    peek(1, rv);  chk("R6 cleared after read", rv, 8'h00);
    pulse(0, 1);
    wrReg(1, 8'h00); peek(1, rv); chk("R6 write to int ignored", rv, 8'hA0);
    rdReg(1, rv);
  endtask

  task automatic tMask();
    wrReg(0, 8'hC0);           // pin enable, tx masked
    pulse(1, 0);
    @(negedge clk);
    peek(1, rv); chk("R4 masked tx no summary", rv, 8'h40);
    chk("R4 pin stays low", {7'd0, irqPin}, 8'd0);
    pulse(0, 1);
    peek(1, rv); chk("R4 unmasked rx summary", rv, 8'hE0);
    rdReg(1, rv);
  endtask

  task automatic tPin();
    wrReg(0, 8'h80);
    @(negedge clk); rxDoneEv = 1;
    @(negedge clk); rxDoneEv = 0;
    chk("R5 pin not yet", {7'd0, irqPin}, 8'd0);
    @(negedge clk);
    chk("R5 pin one cycle later", {7'd0, irqPin}, 8'd1);
    wrReg(0, 8'h00);
    @(negedge clk);
    chk("R5 enable off pin low", {7'd0, irqPin}, 8'd0);
    rdReg(1, rv);
  endtask

  task automatic tCollide();
    @(negedge clk); regSel = 1; regRd = 1; rxDoneEv = 1; #1 rv = regRdata;
    @(negedge clk); regRd = 0; rxDoneEv = 0;
    chk("R7 read returns old", rv, 8'h00);
    peek(1, rv); chk("R7 event kept", rv, 8'hA0);
    rdReg(1, rv);
  endtask

  task automatic tGate();
    wrReg(0, 8'h00);
    frame("R9 filter fail", 100, 0, 0, 0, 0);
    frame("R8 normal accept", 100, 1, 0, 0, 1);
    frame("R10 echo blocked", 100, 1, 1, 0, 0);
    frame("R11 full duplex echo ok", 100, 1, 1, 1, 1);
    frame("R12 runt dropped", 63, 1, 0, 0, 0);
    frame("R12 64 bytes normal", 64, 1, 0, 0, 1);
    wrReg(0, 8'h0C);
    frame("R10 loopback accepts", 100, 1, 1, 0, 1);
    frame("R12 runt accepted", 10, 1, 0, 0, 1);
    frame("R9 runt filter fail", 10, 0, 0, 1, 0);
    // command write in the same cycle as frameEnd: old command used
    @(negedge clk); regSel = 0; regWr = 1; regWdata = 8'h00;
    frameEnd = 1; frameLen = 16'd20; filterPass = 1; txActive = 0; fullDuplex = 0;
    @(negedge clk); regWr = 0; frameEnd = 0;
    chk("R12 judged with old runt bit", {6'd0, frameAccept, frameDrop}, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tReset();
    tCmdLayout();
    tStatus();
    tMask();
    tPin();
    tCollide();
    tGate();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule